// File: doc/BRIEF.md
# Frame-Aligning Lane Deinterleaver

This block sits behind a 1:4 bit deinterleaver. Four lanes arrive, one bit per lane per lane clock. Because the deserializer starts up at an arbitrary bit phase, the lanes can land on the wrong output ports. The block routes the lanes to four output ports through a rotation index. It then watches the stream on the reference port (output channel 4, index 3) for the 32-bit framing word. The rotation advances until that word appears where it should.

The transmitter inverts its channel 4 before interleaving, so that this channel can be told apart from the others. The block inverts output port 3 again to restore the data. It searches for the framing word on the corrected stream. The framing word can therefore only match when the true reference channel is routed to port 3. A hunt/confirm/locked state machine applies hysteresis and drives an in-frame flag that is high when in frame and low while searching.

Top module: `frame_align_deint`

## Requirements
- R1: After `rst` is high, `frame_ok` is 0 and the rotation is 0: output port k carries lane k, and port 3 is inverted.
- R2: Output port k carries lane (k + rot) mod 4. The value is registered and appears one lane clock after it is sampled.
- R3: Port 3 (channel 4) is inverted when it is output. A transmitter that inverts its channel 4 gets its original data back on every port once framing is found.
- R4: The detector compares the last 32 corrected bits of port 3 against 32'hF6F62828. This is the words F6, F6, 28, 28. The earliest-arriving bit is compared against the MSB.
- R5: While hunting, if no match is seen for TIMEOUT_CYC lane clocks, the rotation steps by one (modulo 4) and the timeout restarts.
- R6: A first match starts a position count. Lock is declared only if a second match falls exactly FRAME_CYC lane clocks later. A miss at that point returns the block to hunting.
- R7: While locked, the block checks every FRAME_CYC lane clocks. A match clears the miss count. Up to 3 consecutive misses keep the lock. The 4th consecutive miss returns the block to hunting.
- R8: `frame_ok` is 1 exactly while locked. It rises one lane clock after the confirming match.
- R9: When `frame_rst_n` is low at a clock edge, the block returns to hunting and `frame_ok` is 0 from the next edge on. The rotation index is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_rst_n | input | 1 | Synchronous active-low restart of the framing search |
| lane_in | input | 4 | One bit from each deinterleaved lane |
| lane_out | output | 4 | Rotated, corrected output ports, registered |
| frame_ok | output | 1 | High while in frame, low while hunting |

## Verification
Constant lane levels (only lane 0 high) expose the rotation index directly on the ports. Sampling mid-window after each timeout tells a correct modulo-4 step apart from a missed or doubled one. Framed traffic with random payload and lane skews of 2 and 3 must lock at the matching rotation and return every channel unchanged, which separates correct routing and inversion from an off-by-one. Runs of exactly 3 and then 4 corrupted framing words separate the forgiven case from the lock loss. A good/bad/good/good sequence after a frame restart shows that one match alone never declares lock and that the rotation survives the restart.

// File: rtl/frame_align_pkg.sv
package frame_align_pkg;
  localparam int unsigned WORD_W = 32;
  localparam logic [WORD_W-1:0] FA_WORD = 32'hF6F62828;

  typedef enum logic [1:0] {
    ST_HUNT    = 2'd0,
    ST_CONFIRM = 2'd1,
    ST_LOCKED  = 2'd2
  } fa_state_e;
endpackage

// File: rtl/lane_rotator.sv
module lane_rotator #(
  parameter int LANES    = 4,
  parameter int REF_PORT = LANES - 1,
  localparam int ROT_W   = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ROT_W-1:0] rot,
  input  logic [LANES-1:0] lane_in,
  output logic [LANES-1:0] port_out,
  output logic             ref_bit
);
  logic [LANES-1:0] fixed;

  for (genvar k = 0; k < LANES; k++) begin : g_port
    logic [ROT_W:0]   sum;
    logic [ROT_W-1:0] src;
    always_comb begin
      sum = (ROT_W+1)'(k) + {1'b0, rot};
      if (sum >= (ROT_W+1)'(LANES)) sum = sum - (ROT_W+1)'(LANES);
      src = sum[ROT_W-1:0];
    end
    if (k == REF_PORT) begin : g_ref
      assign fixed[k] = ~lane_in[src];
    end else begin : g_plain
      assign fixed[k] = lane_in[src];
    end
  end

  assign ref_bit = fixed[REF_PORT];

  always_ff @(posedge clk) begin
    if (rst) port_out <= '0;
    else     port_out <= fixed;
  end
endmodule

// File: rtl/frame_hunter.sv
module frame_hunter
  import frame_align_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic bit_in,
  output logic hit
);
  logic [WORD_W-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst || clear) sh <= '0;
    else              sh <= {sh[WORD_W-2:0], bit_in};
  end

  assign hit = (sh == FA_WORD);

  // a rotation step flushes the window, so no match can follow at once
  p_no_hit_after_step_r5: assert property (@(posedge clk) disable iff (rst)
    clear |=> !hit);
endmodule

// File: rtl/frame_fsm.sv
module frame_fsm
  import frame_align_pkg::*;
#(
  parameter int LANES       = 4,
  parameter int TIMEOUT_CYC = 155520,
  parameter int FRAME_CYC   = 77760,
  parameter int MISS_LIMIT  = 4,
  localparam int ROT_W  = $clog2(LANES),
  localparam int TMR_W  = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1,
  localparam int POS_W  = $clog2(FRAME_CYC + 1),
  localparam int MISS_W = (MISS_LIMIT > 1) ? $clog2(MISS_LIMIT) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_rst_n,
  input  logic             hit,
  output logic [ROT_W-1:0] rot,
  output logic             rot_step,
  output logic             frame_ok
);
  fa_state_e   st;
  logic [TMR_W-1:0]  tmr;
  logic [POS_W-1:0]  pos;
  logic [MISS_W-1:0] miss;
  logic              at_check;

  assign at_check = (pos == POS_W'(FRAME_CYC));
  assign rot_step = frame_rst_n && (st == ST_HUNT) && !hit &&
                    (tmr == TMR_W'(TIMEOUT_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_HUNT; tmr <= '0; pos <= '0; miss <= '0;
      rot <= '0; frame_ok <= 1'b0;
    end else if (!frame_rst_n) begin
      st <= ST_HUNT; tmr <= '0; pos <= '0; miss <= '0;
      frame_ok <= 1'b0;
    end else begin
      case (st)
        ST_HUNT: begin
          if (hit) begin
            st <= ST_CONFIRM; pos <= POS_W'(1); tmr <= '0;
          end else if (rot_step) begin
            tmr <= '0;
            if (rot == ROT_W'(LANES - 1)) rot <= '0;
            else                          rot <= rot + 1'b1;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_CONFIRM: begin
          if (at_check) begin
            if (hit) begin
              st <= ST_LOCKED; frame_ok <= 1'b1; pos <= POS_W'(1); miss <= '0;
            end else begin
              st <= ST_HUNT; tmr <= '0;
            end
          end else begin
            pos <= pos + 1'b1;
          end
        end
        ST_LOCKED: begin
          if (at_check) begin
            pos <= POS_W'(1);
            if (hit) begin
              miss <= '0;
            end else if (miss == MISS_W'(MISS_LIMIT - 1)) begin
              st <= ST_HUNT; frame_ok <= 1'b0; tmr <= '0; miss <= '0;
            end else begin
              miss <= miss + 1'b1;
            end
          end else begin
            pos <= pos + 1'b1;
          end
        end
        default: st <= ST_HUNT;
      endcase
    end
  end

  p_rot_in_hunt_r5: assert property (@(posedge clk) disable iff (rst)
    (rot != $past(rot)) |-> ($past(st) == ST_HUNT && !$past(hit)));

  p_lock_two_hits_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(frame_ok) |-> ($past(st) == ST_CONFIRM && $past(hit)));

  p_drop_on_fourth_miss_r7: assert property (@(posedge clk) disable iff (rst)
    ($fell(frame_ok) && $past(frame_rst_n)) |->
      (!$past(hit) && $past(miss) == MISS_W'(MISS_LIMIT - 1)));

  p_frame_restart_r9: assert property (@(posedge clk) disable iff (rst)
    !frame_rst_n |=> (!frame_ok && st == ST_HUNT));
endmodule

// File: rtl/frame_align_deint.sv
module frame_align_deint #(
  parameter int LANES       = 4,
  parameter int TIMEOUT_CYC = 155520,
  parameter int FRAME_CYC   = 77760,
  parameter int MISS_LIMIT  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_rst_n,
  input  logic [LANES-1:0] lane_in,
  output logic [LANES-1:0] lane_out,
  output logic             frame_ok
);
  localparam int ROT_W = $clog2(LANES);

  logic [ROT_W-1:0] rot;
  logic             rot_step;
  logic             ref_bit;
  logic             hit;

  lane_rotator #(.LANES(LANES), .REF_PORT(LANES - 1)) u_rot (
    .clk(clk), .rst(rst), .rot(rot), .lane_in(lane_in),
    .port_out(lane_out), .ref_bit(ref_bit)
  );

  frame_hunter u_hunt (
    .clk(clk), .rst(rst), .clear(rot_step), .bit_in(ref_bit), .hit(hit)
  );

  frame_fsm #(
    .LANES(LANES), .TIMEOUT_CYC(TIMEOUT_CYC),
    .FRAME_CYC(FRAME_CYC), .MISS_LIMIT(MISS_LIMIT)
  ) u_fsm (
    .clk(clk), .rst(rst), .frame_rst_n(frame_rst_n), .hit(hit),
    .rot(rot), .rot_step(rot_step), .frame_ok(frame_ok)
  );
endmodule

// File: tb/frame_align_deint_tb.sv
module frame_align_deint_tb;
  localparam int TO = 300;
  localparam int FR = 96;
  localparam logic [31:0] WORD = 32'hF6F62828;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_rst_n = 1'b1;
  logic [3:0] lane_in = 4'b0;
  logic [3:0] lane_out;
  logic frame_ok;

  always #2 clk = ~clk;

  frame_align_deint #(.LANES(4), .TIMEOUT_CYC(TO), .FRAME_CYC(FR), .MISS_LIMIT(4)) u_dut (
    .clk(clk), .rst(rst), .frame_rst_n(frame_rst_n),
    .lane_in(lane_in), .lane_out(lane_out), .frame_ok(frame_ok)
  );

  int total = 0, bad = 0, wd = 0;
  bit const_mode = 1'b1;
  logic [3:0] const_val = 4'b0001;
  int skew = 0;
  int cpos [4];
  int rpos = 0, rframe = 0;
  logic [7:0] sched = '0;
  bit corrupt_now = 1'b0;
  bit chk_data = 1'b0;
  int data_err = 0;
  logic [3:0] prev_tx = '0;

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=<150000", wd);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [3:0] exp_map(input logic [3:0] l, input int r);
    logic [3:0] o;
    for (int k = 0; k < 4; k++) o[k] = l[(k + r) % 4];
    o[3] = ~o[3];
    return o;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    logic [3:0] tx, li;
    logic b;
    @(negedge clk);
    if (chk_data && lane_out !== prev_tx) data_err++;
    if (const_mode) begin
      lane_in = const_val;
    end else begin
      tx = '0; li = '0;
      for (int c = 0; c < 4; c++) begin
        if (c == 3 && cpos[3] == 0) begin
          corrupt_now = sched[0]; sched = sched >> 1; rframe++;
        end
        if (cpos[c] < 32) b = WORD[31 - cpos[c]];
        else              b = 1'($urandom);
        if (c == 3 && corrupt_now && cpos[3] == 31) b = ~b;
        tx[c] = b;
        li[(c + skew) % 4] = b ^ (c == 3);
        if (c == 3) rpos = cpos[3];
        cpos[c] = (cpos[c] + 1) % FR;
      end
      lane_in = li; prev_tx = tx;
    end
  endtask

  task automatic wait_at(input int nfr, input int p);
    int target;
    target = rframe + nfr;
    do step(); while (!(rframe == target && rpos == p));
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) step();
    rst = 1'b0;
  endtask

  task automatic start_stream(input int s);
    const_mode = 1'b0; skew = s; sched = '0;
    for (int c = 0; c < 4; c++) cpos[c] = $urandom % FR;
  endtask

  task automatic data_window(input string req);
    data_err = 0; chk_data = 1'b1;
    repeat (200) step();
    chk_data = 1'b0;
    chk(data_err == 0, req, data_err, 0);
  endtask

  task automatic wait_lock(input string req);
    int n;
    n = 0;
    while (!frame_ok && n < 3000) begin step(); n++; end
    chk(frame_ok === 1'b1, req, frame_ok, 1);
  endtask

  initial begin
    int zeros;
    void'($urandom(32'd1234));
    // R1 reset state, R2 rotation visible on constant lanes
    const_mode = 1'b1; const_val = 4'b0001;
    do_reset();
    step();
    chk(frame_ok === 1'b0, "R1 frame_ok after reset", frame_ok, 0);
    chk(lane_out === exp_map(4'b0001, 0), "R1 identity rotation", lane_out, exp_map(4'b0001, 0));
    // R5 timeout stepping, sampled mid-window
    for (int k = 0; k < 5; k++) begin
      while (wd < 0) step();
      repeat ((k == 0) ? (TO / 2 - 1) : TO) step();
      chk(lane_out === exp_map(4'b0001, k % 4), "R5 R2 rotation after timeout", lane_out, exp_map(4'b0001, k % 4));
      chk(frame_ok === 1'b0, "R8 no lock without framing", frame_ok, 0);
    end

    // R4 R6 lock with skew 2, R2 R3 data restored
    do_reset();
    start_stream(2);
    wait_lock("R4 R6 lock at skew 2");
    data_window("R2 R3 channels restored skew 2");

    // R7 three misses forgiven
    wait_at(1, 60);
    sched = 8'b0000_0111;
    zeros = 0;
    do begin step(); if (frame_ok !== 1'b1) zeros++; end
    while (!(rframe == rframe && sched == 0 && rpos == 60 && !corrupt_now));
    chk(zeros == 0, "R7 three misses keep lock", zeros, 0);

    // R7 fourth miss drops, R6 relock needs two hits
    wait_at(1, 60);
    sched = 8'b0000_1111;
    wait_at(3, 60);
    chk(frame_ok === 1'b1, "R7 lock held through third miss", frame_ok, 1);
    wait_at(1, 60);
    chk(frame_ok === 1'b0, "R7 R8 fourth miss drops lock", frame_ok, 0);
    wait_at(1, 60);
    chk(frame_ok === 1'b0, "R6 one hit is not lock", frame_ok, 0);
    wait_at(1, 60);
    chk(frame_ok === 1'b1, "R6 R8 relock on second hit", frame_ok, 1);

    // R9 frame restart, then good/bad/good/good
    wait_at(1, 60);
    sched = 8'b0000_0010;
    frame_rst_n = 1'b0;
    step();
    frame_rst_n = 1'b1;
    step();
    chk(frame_ok === 1'b0, "R9 restart clears frame_ok", frame_ok, 0);
    wait_at(1, 60);
    chk(frame_ok === 1'b0, "R6 first hit only", frame_ok, 0);
    wait_at(1, 60);
    chk(frame_ok === 1'b0, "R6 miss in confirm", frame_ok, 0);
    wait_at(1, 60);
    chk(frame_ok === 1'b0, "R6 fresh first hit", frame_ok, 0);
    wait_at(1, 60);
    chk(frame_ok === 1'b1, "R6 confirmed lock", frame_ok, 1);
    data_window("R9 rotation kept across restart");

    // skew 3 from reset
    do_reset();
    start_stream(3);
    wait_lock("R5 R6 lock at skew 3");
    data_window("R2 R3 channels restored skew 3");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule